// File: doc/BRIEF.md
# Clock Synthesizer Lock Sequencer

This block holds the programming registers for three clock synthesizers and decides when each synthesizer's output may be used. Every channel has a lock-time word and a configuration word. The configuration word holds an enable bit and three divider fields, M, P and S. The divider fields and the enable go straight out to the synthesizer. The block then counts reference-clock cycles until the programmed settling time has passed. Until that count finishes, the channel's output-valid flag stays low and its gated clock output is forced to 0.

A countdown starts when software switches a channel on. It also starts when software writes new divider values into a channel that is already on. A rewrite that leaves the dividers unchanged has no effect on a running or finished lock. Clearing the enable drops the channel at once. The third channel has a second, auxiliary configuration word. That word is stored and can be read back, but it does not affect the sequencing. The register port is word-indexed and synchronous to the reference clock. Reads are combinational from the index.

Top module: `clksyn_lock_ctrl`

## Requirements
- R1: After reset the lock-time words read 0x0000FFFF. The configuration words read 0x01900302 (channel 0), 0x02140603 (channel 1) and 0x00200102 (channel 2). The auxiliary word reads 0x00009111. All enables and all output-valid flags are 0.
- R2: Register index 0, 1 and 2 select the lock times of channels 0, 1 and 2. Index 3, 4 and 5 select the configuration words of channels 0, 1 and 2. Index 6 selects the auxiliary word. Index 7 reads 0, and a write to index 7 changes nothing.
- R3: A lock-time word stores bits [15:0]. Bits [31:16] ignore writes and read as 0.
- R4: A configuration word has the enable in bit 31, M in [25:16], P in [13:8] and S in [2:0]. All other bits read 0. The enable and divider outputs always follow the stored word, with channel i at slice i of each packed output.
- R5: A write that sets the enable of a disabled channel, with lock time L, makes that channel's valid flag rise at the (L+1)-th clock edge after the write edge. The flag is 0 before that edge.
- R6: A write that changes any divider field of an enabled channel clears its valid flag at the write edge. The countdown then restarts with the current lock time.
- R7: A write to an enabled channel's configuration word that keeps the enable set and leaves M, P and S unchanged does not disturb its valid flag or its countdown.
- R8: A write that clears the enable drops the channel's valid flag at the write edge. The flag stays 0 until the channel is started again.
- R9: Each gated clock output equals the channel's raw synthesizer input ANDed with its valid flag.
- R10: The auxiliary word stores all 32 bits. Writing it changes no output of channel 2.
- R11: With a lock time of 0, the valid flag is back at 1 one edge after the triggering write.
- R12: The channels count independently. Starting one channel does not change another channel's valid flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock; also clocks the register port |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Write strobe for the register port |
| reg_addr_i | input | 3 | Word index of the register |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i (combinational) |
| syn_clk_i | input | 3 | Raw synthesizer outputs, one per channel |
| syn_en_o | output | 3 | Enable for each synthesizer |
| syn_mdiv_o | output | 30 | M divider, 10 bits per channel |
| syn_pdiv_o | output | 18 | P divider, 6 bits per channel |
| syn_sdiv_o | output | 9 | S divider, 3 bits per channel |
| lock_valid_o | output | 3 | Lock period elapsed, per channel |
| gated_clk_o | output | 3 | Raw synthesizer output masked by lock_valid_o |

## Verification
The assertions assume the register port is driven synchronously to the reference clock. They also assume that a start and a stop for the same channel never arrive together. The register bank can only issue one of the two, because a single write either sets or clears the enable. The stimulus writes one register per access and leaves an idle cycle between accesses. It keeps every lock time small, so each countdown finishes well inside the run. Reset is applied only at the start.

// File: rtl/clksyn_pkg.sv
package clksyn_pkg;
    localparam int NUM_SYN  = 3;
    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 3;
    localparam int LOCK_W   = 16;
    localparam int M_W      = 10;
    localparam int P_W      = 6;
    localparam int S_W      = 3;
    localparam int EN_BIT   = 31;
    localparam int M_LSB    = 16;
    localparam int P_LSB    = 8;
    localparam int S_LSB    = 0;
    localparam int DIV_W    = M_W + P_W + S_W;
    localparam int CFG_BASE = NUM_SYN;
    localparam int AUX_IDX  = 2 * NUM_SYN;

    localparam logic [DATA_W-1:0] LOCK_MASK = (DATA_W)'((1 << LOCK_W) - 1);
    localparam logic [DATA_W-1:0] CFG_MASK  =
        (DATA_W'(1) << EN_BIT) |
        (DATA_W'((1 << M_W) - 1) << M_LSB) |
        (DATA_W'((1 << P_W) - 1) << P_LSB) |
        (DATA_W'((1 << S_W) - 1) << S_LSB);

    localparam logic [LOCK_W-1:0] LOCK_RST = '1;
    localparam logic [NUM_SYN-1:0][DATA_W-1:0] CFG_RST =
        {32'h0020_0102, 32'h0214_0603, 32'h0190_0302};
    localparam logic [DATA_W-1:0] AUX_RST = 32'h0000_9111;

    function automatic logic [DIV_W-1:0] divs_of(input logic [DATA_W-1:0] w);
        return {w[M_LSB +: M_W], w[P_LSB +: P_W], w[S_LSB +: S_W]};
    endfunction
endpackage

// File: rtl/clksyn_regbank.sv
module clksyn_regbank
    import clksyn_pkg::*;
(
    input  logic                              clk_i,
    input  logic                              rst_ni,
    input  logic                              wr_i,
    input  logic [ADDR_W-1:0]                 addr_i,
    input  logic [DATA_W-1:0]                 wdata_i,
    output logic [DATA_W-1:0]                 rdata_o,
    output logic [NUM_SYN-1:0][LOCK_W-1:0]    lock_time_o,
    output logic [NUM_SYN-1:0][DATA_W-1:0]    cfg_o,
    output logic [NUM_SYN-1:0]                start_o,
    output logic [NUM_SYN-1:0]                stop_o
);
    typedef struct packed {
        logic [NUM_SYN-1:0][LOCK_W-1:0] lock;
        logic [NUM_SYN-1:0][DATA_W-1:0] cfg;
        logic [DATA_W-1:0]              aux;
    } bank_t;

    bank_t bank_d, bank_q;
    logic [NUM_SYN-1:0] start_d, stop_d;

    always_comb begin
        bank_d  = bank_q;
        start_d = '0;
        stop_d  = '0;
        if (wr_i) begin
            for (int i = 0; i < NUM_SYN; i++) begin
                if (int'(addr_i) == i) begin
                    bank_d.lock[i] = wdata_i[LOCK_W-1:0];
                end
                if (int'(addr_i) == CFG_BASE + i) begin
                    bank_d.cfg[i] = wdata_i & CFG_MASK;
                    if (wdata_i[EN_BIT]) begin
                        start_d[i] = !bank_q.cfg[i][EN_BIT] ||
                                     (divs_of(wdata_i) != divs_of(bank_q.cfg[i]));
                    end else begin
                        stop_d[i] = 1'b1;
                    end
                end
            end
            if (int'(addr_i) == AUX_IDX) begin
                bank_d.aux = wdata_i;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int i = 0; i < NUM_SYN; i++) begin
                bank_q.lock[i] <= LOCK_RST;
                bank_q.cfg[i]  <= CFG_RST[i];
            end
            bank_q.aux <= AUX_RST;
        end else begin
            bank_q <= bank_d;
        end
    end

    always_comb begin
        rdata_o = '0;
        for (int i = 0; i < NUM_SYN; i++) begin
            if (int'(addr_i) == i) begin
                rdata_o = (DATA_W)'(bank_q.lock[i]);
            end
            if (int'(addr_i) == CFG_BASE + i) begin
                rdata_o = bank_q.cfg[i];
            end
        end
        if (int'(addr_i) == AUX_IDX) begin
            rdata_o = bank_q.aux;
        end
    end

    assign lock_time_o = bank_q.lock;
    assign cfg_o       = bank_q.cfg;
    assign start_o     = start_d;
    assign stop_o      = stop_d;

    AST_LOCK_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (int'(addr_i) < NUM_SYN) |-> ((rdata_o & ~LOCK_MASK) == '0)); // R3
    AST_CFG_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (int'(addr_i) >= CFG_BASE && int'(addr_i) < AUX_IDX)
            |-> ((rdata_o & ~CFG_MASK) == '0)); // R4
    AST_ONE_ACTION: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $countones(start_o | stop_o) <= 1); // R2
endmodule

// File: rtl/clksyn_lock_seq.sv
module clksyn_lock_seq
    import clksyn_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic [LOCK_W-1:0] lock_time_i,
    output logic              valid_o
);
    typedef struct packed {
        logic              busy;
        logic              valid;
        logic [LOCK_W-1:0] cnt;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        if (stop_i) begin
            seq_d.busy  = 1'b0;
            seq_d.valid = 1'b0;
        end else if (start_i) begin
            seq_d.busy  = 1'b1;
            seq_d.valid = 1'b0;
            seq_d.cnt   = lock_time_i;
        end else if (seq_q.busy) begin
            if (seq_q.cnt == '0) begin
                seq_d.busy  = 1'b0;
                seq_d.valid = 1'b1;
            end else begin
                seq_d.cnt = seq_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign valid_o = seq_q.valid;

    AST_START_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_i && !stop_i) |=> (!valid_o && seq_q.busy)); // R6
    AST_STOP_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stop_i |=> (!valid_o && !seq_q.busy)); // R8
    AST_ZERO_EXPIRES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (seq_q.busy && seq_q.cnt == '0 && !start_i && !stop_i) |=> valid_o); // R11
    AST_NO_VALID_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        seq_q.busy |-> !valid_o); // R5
endmodule

// File: rtl/clksyn_lock_ctrl.sv
module clksyn_lock_ctrl
    import clksyn_pkg::*;
(
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic                    reg_wr_i,
    input  logic [ADDR_W-1:0]       reg_addr_i,
    input  logic [DATA_W-1:0]       reg_wdata_i,
    output logic [DATA_W-1:0]       reg_rdata_o,
    input  logic [NUM_SYN-1:0]      syn_clk_i,
    output logic [NUM_SYN-1:0]      syn_en_o,
    output logic [NUM_SYN*M_W-1:0]  syn_mdiv_o,
    output logic [NUM_SYN*P_W-1:0]  syn_pdiv_o,
    output logic [NUM_SYN*S_W-1:0]  syn_sdiv_o,
    output logic [NUM_SYN-1:0]      lock_valid_o,
    output logic [NUM_SYN-1:0]      gated_clk_o
);
    logic [NUM_SYN-1:0][LOCK_W-1:0] lock_time;
    logic [NUM_SYN-1:0][DATA_W-1:0] cfg;
    logic [NUM_SYN-1:0]             start, stop;

    clksyn_regbank u_bank (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .wr_i        (reg_wr_i),
        .addr_i      (reg_addr_i),
        .wdata_i     (reg_wdata_i),
        .rdata_o     (reg_rdata_o),
        .lock_time_o (lock_time),
        .cfg_o       (cfg),
        .start_o     (start),
        .stop_o      (stop)
    );

    for (genvar g = 0; g < NUM_SYN; g++) begin : g_chan
        clksyn_lock_seq u_seq (
            .clk_i       (clk_i),
            .rst_ni      (rst_ni),
            .start_i     (start[g]),
            .stop_i      (stop[g]),
            .lock_time_i (lock_time[g]),
            .valid_o     (lock_valid_o[g])
        );

        assign syn_en_o[g]               = cfg[g][EN_BIT];
        assign syn_mdiv_o[g*M_W +: M_W]  = cfg[g][M_LSB +: M_W];
        assign syn_pdiv_o[g*P_W +: P_W]  = cfg[g][P_LSB +: P_W];
        assign syn_sdiv_o[g*S_W +: S_W]  = cfg[g][S_LSB +: S_W];
        assign gated_clk_o[g]            = syn_clk_i[g] & lock_valid_o[g];

        AST_VALID_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
            lock_valid_o[g] |-> syn_en_o[g]); // R8
        AST_SAME_DIVS_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (reg_wr_i && int'(reg_addr_i) == CFG_BASE + g && reg_wdata_i[EN_BIT] &&
             syn_en_o[g] && lock_valid_o[g] &&
             divs_of(reg_wdata_i) == divs_of(cfg[g])) |=> lock_valid_o[g]); // R7
        AST_AUX_NO_EFFECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (reg_wr_i && int'(reg_addr_i) == AUX_IDX)
                |=> ($stable(lock_valid_o[g]) && $stable(cfg[g]))); // R10
    end
endmodule

// File: tb/tb_clksyn_lock_ctrl.sv
module tb_clksyn_lock_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [2:0]  syn_clk = 3'b111;
    logic [2:0]  syn_en, lock_valid, gated_clk;
    logic [29:0] mdiv;
    logic [17:0] pdiv;
    logic [8:0]  sdiv;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    typedef struct {
        int    at;
        int    ch;
        logic  val;
        string req;
    } exp_t;
    exp_t sb[$];
    exp_t cur;

    clksyn_lock_ctrl dut (
        .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
        .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .syn_clk_i(syn_clk),
        .syn_en_o(syn_en), .syn_mdiv_o(mdiv), .syn_pdiv_o(pdiv), .syn_sdiv_o(sdiv),
        .lock_valid_o(lock_valid), .gated_clk_o(gated_clk)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: pops scoreboard items when their cycle arrives
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].at <= cyc) begin
            cur = sb.pop_front();
            chk(cur.req, 32'(lock_valid[cur.ch]), 32'(cur.val));
        end
    end

    task automatic push(input int at, input int ch, input logic v, input string r);
        exp_t e;
        e.at = at; e.ch = ch; e.val = v; e.req = r;
        sb.push_back(e);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d, output int w);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        w = cyc;
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin : stim
        int w;
        logic [31:0] d;
        idle(3);
        rst_n = 1'b1;
        idle(2);

        // R1 reset values
        rd(3'd0, d); chk("R1 lock0", d, 32'h0000_FFFF);
        rd(3'd1, d); chk("R1 lock1", d, 32'h0000_FFFF);
        rd(3'd2, d); chk("R1 lock2", d, 32'h0000_FFFF);
        rd(3'd3, d); chk("R1 cfg0", d, 32'h0190_0302);
        rd(3'd4, d); chk("R1 cfg1", d, 32'h0214_0603);
        rd(3'd5, d); chk("R1 cfg2", d, 32'h0020_0102);
        rd(3'd6, d); chk("R1 aux", d, 32'h0000_9111);
        chk("R1 en", 32'(syn_en), 32'h0);
        chk("R1 valid", 32'(lock_valid), 32'h0);
        chk("R4 mdiv0 reset", 32'(mdiv[9:0]), 32'h190);

        // R3 lock width
        wr(3'd0, 32'hABCD_0005, w);
        rd(3'd0, d); chk("R3 lock0 masked", d, 32'h0000_0005);

        // R4 field layout on disabled channel 1
        wr(3'd4, 32'h7FFF_FFFF, w);
        rd(3'd4, d); chk("R4 cfg1 masked", d, 32'h03FF_3F07);
        chk("R4 mdiv1", 32'(mdiv[19:10]), 32'h3FF);
        chk("R4 pdiv1", 32'(pdiv[11:6]), 32'h3F);
        chk("R4 sdiv1", 32'(sdiv[5:3]), 32'h7);
        chk("R4 en1 off", 32'(syn_en[1]), 32'h0);
        chk("R4 valid1 off", 32'(lock_valid[1]), 32'h0);

        // R5 enable channel 0 with lock time 5
        wr(3'd3, 32'h8190_0302, w);
        chk("R9 gated low in lock", 32'(gated_clk[0]), 32'h0);
        push(w + 1, 0, 1'b0, "R5 low early");
        push(w + 5, 0, 1'b0, "R5 low last");
        push(w + 6, 0, 1'b1, "R5 rise");
        idle(10);
        chk("R4 en0", 32'(syn_en[0]), 32'h1);

        // R9 gating
        syn_clk = 3'b111; #1;
        chk("R9 gated pass", 32'(gated_clk), 32'h1);
        syn_clk = 3'b110; #1;
        chk("R9 gated raw low", 32'(gated_clk), 32'h0);
        syn_clk = 3'b111;

        // R7 identical rewrite
        wr(3'd3, 32'h8190_0302, w);
        chk("R7 no drop", 32'(lock_valid[0]), 32'h1);
        push(w + 1, 0, 1'b1, "R7 held");
        push(w + 3, 0, 1'b1, "R7 held later");
        idle(5);

        // R6 change M divider
        wr(3'd3, 32'h8191_0302, w);
        chk("R6 drop", 32'(lock_valid[0]), 32'h0);
        push(w + 5, 0, 1'b0, "R6 still low");
        push(w + 6, 0, 1'b1, "R6 relock");
        idle(10);

        // R11 zero lock time, change S
        wr(3'd0, 32'h0000_0000, w);
        wr(3'd3, 32'h8191_0303, w);
        chk("R11 low at write", 32'(lock_valid[0]), 32'h0);
        push(w + 1, 0, 1'b1, "R11 next cycle");
        idle(4);

        // R8 disable
        wr(3'd3, 32'h0191_0303, w);
        chk("R8 drop", 32'(lock_valid[0]), 32'h0);
        push(w + 1, 0, 1'b0, "R8 low");
        push(w + 4, 0, 1'b0, "R8 stays low");
        idle(6);

        // R10 channel 2 and auxiliary word
        wr(3'd2, 32'h0000_0003, w);
        wr(3'd5, 32'h8020_0102, w);
        push(w + 3, 2, 1'b0, "R5 ch2 low");
        push(w + 4, 2, 1'b1, "R5 ch2 rise");
        idle(8);
        wr(3'd6, 32'hDEAD_BEEF, w);
        push(w + 1, 2, 1'b1, "R10 held");
        push(w + 3, 2, 1'b1, "R10 held later");
        idle(5);
        rd(3'd6, d); chk("R10 aux stored", d, 32'hDEAD_BEEF);
        chk("R10 mdiv2", 32'(mdiv[29:20]), 32'h020);
        chk("R10 sdiv2", 32'(sdiv[8:6]), 32'h2);

        // R12 independence
        wr(3'd1, 32'h0000_0008, w);
        wr(3'd4, 32'h8214_0603, w);
        push(w + 2, 2, 1'b1, "R12 ch2 kept");
        push(w + 8, 1, 1'b0, "R12 ch1 low");
        push(w + 9, 1, 1'b1, "R12 ch1 rise");
        idle(12);
        chk("R12 ch0 still off", 32'(lock_valid[0]), 32'h0);

        // R2 map and unused index
        wr(3'd7, 32'hFFFF_FFFF, w);
        rd(3'd7, d); chk("R2 idx7 zero", d, 32'h0);
        rd(3'd1, d); chk("R2 lock1", d, 32'h0000_0008);
        rd(3'd5, d); chk("R2 cfg2", d, 32'h8020_0102);
        chk("R2 valid unchanged", 32'(lock_valid), 32'h6);

        idle(2);
        if (sb.size() != 0) begin
            fails++;
            $display("FAIL scoreboard actual=%0d expected=0 pending", sb.size());
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule